// File: doc/BRIEF.md
# Precision Time Event Snapshot and Lock Unit

This block records the value of a free-running 64-bit system time at the moment a precision time protocol event message passes through one of up to eight Ethernet channels. Each channel has its own receive snapshot and its own transmit snapshot. Each snapshot has a status flag that shows a capture has been taken. While the flag is set, that snapshot is frozen until software has read it and cleared the flag.

The receive and transmit message parsers send one strobe per message kind (Sync, Delay_Req) and per direction. A per-channel role input picks which strobe counts for each direction. A per-channel "stamp everything" control turns the unit into a plain tracker: the snapshot follows every qualifying message and the flags are left alone. Software reaches the flags and snapshots through a flat, word-addressed register port. Reads are combinational. A flag is cleared by writing one to it.

Top module: `ptp_snap_lock`

## Requirements
- R1: Receive capture trigger: with `role_master[n]`=1 a receive Delay_Req strobe qualifies and a receive Sync strobe does not. With `role_master[n]`=0 the receive Sync strobe qualifies and the receive Delay_Req strobe does not.
- R2: Transmit capture trigger: with `role_master[n]`=1 a transmit Sync strobe qualifies. With `role_master[n]`=0 a transmit Delay_Req strobe qualifies.
- R3: Suppose a qualifying strobe arrives while `ts_all[n]`=0 and the flag is clear. Then `time_now` from the strobe cycle is in that snapshot after the next rising edge, and the flag is set. The receive flag is status bit 1 and the transmit flag is status bit 0.
- R4: While a flag is set and `ts_all[n]`=0, further strobes leave that direction's snapshot unchanged.
- R5: A write with a 1 in bit 1 (receive) or bit 0 (transmit) to a channel's status word clears that flag. A 0 in a bit leaves that flag unchanged.
- R6: If a qualifying strobe and a clearing write hit the same flag in the same cycle, the flag stays set and the snapshot takes the new time.
- R7: With `ts_all[n]`=1, every qualifying strobe loads the snapshot, and that direction's flag keeps its value.
- R8: Status words read zero in bits 31:2.
- R9: After reset all flags and all snapshots read zero.
- R10: Channel n owns the 32-byte window starting at 0x040 + 0x20*n. Within it, +0x04 is status, +0x08/+0x0C are the receive snapshot low/high words, and +0x10/+0x14 are the transmit snapshot low/high words. Every other address reads zero and ignores writes.
- R11: A strobe that does not qualify for the channel's role leaves the flag and the snapshot unchanged.
- R12: A clearing write to one channel's status word leaves every other channel's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | TIME_W | Free-running system time |
| role_master | input | NUM_CH | Per-channel role, 1 = master |
| ts_all | input | NUM_CH | Per-channel stamp-everything control |
| rx_sync | input | NUM_CH | Receive Sync message strobe |
| rx_dreq | input | NUM_CH | Receive Delay_Req message strobe |
| tx_sync | input | NUM_CH | Transmit Sync message strobe |
| tx_dreq | input | NUM_CH | Transmit Delay_Req message strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
A hardware capture and a software clear can land on the same flag in the same clock cycle. The bench provokes this by driving a status write with the receive bit set in the same cycle as a qualifying receive strobe carrying a fresh time value. It then reads the status word and the snapshot words and judges the result by R6: the flag must still be set and the snapshot must hold the new time. A later event must then leave that snapshot frozen.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;
  // byte address of the first channel window and the window size
  localparam int WIN_BASE    = 'h040;
  localparam int WIN_STRIDE  = 'h020;
  localparam int WIN_LG      = 5;

  // word index inside a channel window (byte offset / 4)
  typedef enum logic [2:0] {
    W_STATUS = 3'd1,
    W_RX_LO  = 3'd2,
    W_RX_HI  = 3'd3,
    W_TX_LO  = 3'd4,
    W_TX_HI  = 3'd5
  } win_word_e;

  // flag positions inside the status word
  localparam int BIT_RXF = 1;
  localparam int BIT_TXF = 0;
endpackage

// File: rtl/ptp_snap_dir.sv
module ptp_snap_dir #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              ta,
  input  logic              clr,
  input  logic [TIME_W-1:0] time_now,
  output logic              flag,
  output logic [TIME_W-1:0] snap
);
  logic flag_q, flag_d;
  logic snap_en;
  logic [TIME_W-1:0] snap_q;

  always_comb begin
    // the hardware set dominates a simultaneous clear
    flag_d  = (trig & ~ta) | (flag_q & ~clr);
    // a clear in the same cycle unlocks the snapshot for this event
    snap_en = trig & (ta | ~flag_q | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= time_now;
  end

  assign flag = flag_q;
  assign snap = snap_q;
endmodule

// File: rtl/ptp_snap_chan.sv
module ptp_snap_chan #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              ta,
  input  logic              rx_sync,
  input  logic              rx_dreq,
  input  logic              tx_sync,
  input  logic              tx_dreq,
  input  logic              rx_clr,
  input  logic              tx_clr,
  input  logic [TIME_W-1:0] time_now,
  output logic              rx_flag,
  output logic              tx_flag,
  output logic [TIME_W-1:0] rx_snap,
  output logic [TIME_W-1:0] tx_snap
);
  logic rx_trig, tx_trig;

  // master stamps incoming Delay_Req and outgoing Sync; slave the reverse
  always_comb begin
    rx_trig = master ? rx_dreq : rx_sync;
    tx_trig = master ? tx_sync : tx_dreq;
  end

  ptp_snap_dir #(.TIME_W(TIME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .trig(rx_trig), .ta(ta), .clr(rx_clr),
    .time_now(time_now), .flag(rx_flag), .snap(rx_snap)
  );

  ptp_snap_dir #(.TIME_W(TIME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .trig(tx_trig), .ta(ta), .clr(tx_clr),
    .time_now(time_now), .flag(tx_flag), .snap(tx_snap)
  );
endmodule

// File: rtl/ptp_snap_regif.sv
module ptp_snap_regif
  import ptp_snap_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 64,
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_wr,
  input  logic [31:0]                    reg_wdata,
  input  logic [NUM_CH-1:0]              rx_flag,
  input  logic [NUM_CH-1:0]              tx_flag,
  input  logic [NUM_CH-1:0][TIME_W-1:0]  rx_snap,
  input  logic [NUM_CH-1:0][TIME_W-1:0]  tx_snap,
  output logic [NUM_CH-1:0]              rx_clr,
  output logic [NUM_CH-1:0]              tx_clr,
  output logic [31:0]                    reg_rdata
);
  localparam int WIN_END = WIN_BASE + NUM_CH * WIN_STRIDE;
  localparam int CHW     = ADDR_W - WIN_LG;

  logic              in_range;
  logic [ADDR_W-1:0] rel;
  logic [2:0]        word;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0][63:0] rx_ext, tx_ext;
  logic              unused_bits;

  assign unused_bits = ^{reg_wdata[31:2], rel[1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ext
    assign rx_ext[c] = 64'(rx_snap[c]);
    assign tx_ext[c] = 64'(tx_snap[c]);
    assign hit[c]    = in_range && (rel[ADDR_W-1:WIN_LG] == CHW'(c));
  end

  always_comb begin
    in_range = (int'(reg_addr) >= WIN_BASE) && (int'(reg_addr) < WIN_END);
    rel      = reg_addr - ADDR_W'(WIN_BASE);
    word     = rel[4:2];
  end

  always_comb begin
    reg_rdata = '0;
    rx_clr    = '0;
    tx_clr    = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) begin
        case (word)
          W_STATUS: begin
            reg_rdata[BIT_RXF] = rx_flag[c];
            reg_rdata[BIT_TXF] = tx_flag[c];
            rx_clr[c] = reg_wr & reg_wdata[BIT_RXF];
            tx_clr[c] = reg_wr & reg_wdata[BIT_TXF];
          end
          W_RX_LO: reg_rdata = rx_ext[c][31:0];
          W_RX_HI: reg_rdata = rx_ext[c][63:32];
          W_TX_LO: reg_rdata = tx_ext[c][31:0];
          W_TX_HI: reg_rdata = tx_ext[c][63:32];
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_snap_lock.sv
module ptp_snap_lock #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 64,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic [NUM_CH-1:0] role_master,
  input  logic [NUM_CH-1:0] ts_all,
  input  logic [NUM_CH-1:0] rx_sync,
  input  logic [NUM_CH-1:0] rx_dreq,
  input  logic [NUM_CH-1:0] tx_sync,
  input  logic [NUM_CH-1:0] tx_dreq,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic [NUM_CH-1:0]             rx_flag, tx_flag;
  logic [NUM_CH-1:0]             rx_clr, tx_clr;
  logic [NUM_CH-1:0][TIME_W-1:0] rx_snap, tx_snap;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ptp_snap_chan #(.TIME_W(TIME_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .master(role_master[c]), .ta(ts_all[c]),
      .rx_sync(rx_sync[c]), .rx_dreq(rx_dreq[c]),
      .tx_sync(tx_sync[c]), .tx_dreq(tx_dreq[c]),
      .rx_clr(rx_clr[c]), .tx_clr(tx_clr[c]),
      .time_now(time_now),
      .rx_flag(rx_flag[c]), .tx_flag(tx_flag[c]),
      .rx_snap(rx_snap[c]), .tx_snap(tx_snap[c])
    );
  end

  ptp_snap_regif #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_regif (
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rx_flag(rx_flag), .tx_flag(tx_flag),
    .rx_snap(rx_snap), .tx_snap(tx_snap),
    .rx_clr(rx_clr), .tx_clr(tx_clr),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/ptp_snap_lock_chk.sv
module ptp_snap_lock_chk #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 64,
  parameter int ADDR_W = 9
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [TIME_W-1:0]             time_now,
  input logic [NUM_CH-1:0]             role_master,
  input logic [NUM_CH-1:0]             ts_all,
  input logic [NUM_CH-1:0]             rx_sync,
  input logic [NUM_CH-1:0]             rx_dreq,
  input logic [NUM_CH-1:0]             tx_sync,
  input logic [NUM_CH-1:0]             tx_dreq,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [31:0]                   reg_rdata,
  input logic [NUM_CH-1:0]             rx_flag,
  input logic [NUM_CH-1:0]             tx_flag,
  input logic [NUM_CH-1:0]             rx_clr,
  input logic [NUM_CH-1:0]             tx_clr,
  input logic [NUM_CH-1:0][TIME_W-1:0] rx_snap,
  input logic [NUM_CH-1:0][TIME_W-1:0] tx_snap
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic rx_q, tx_q;
    assign rx_q = role_master[i] ? rx_dreq[i] : rx_sync[i];
    assign tx_q = role_master[i] ? tx_sync[i] : tx_dreq[i];

    // R1
    rx_trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q && !ts_all[i]) |=> rx_flag[i]);
    // R2
    tx_trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_q && !ts_all[i]) |=> tx_flag[i]);
    // R3
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q && !ts_all[i] && !rx_flag[i]) |=> rx_snap[i] == $past(time_now));
    // R4
    rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag[i] && !rx_clr[i] && !ts_all[i]) |=> $stable(rx_snap[i]));
    // R4
    tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flag[i] && !tx_clr[i] && !ts_all[i]) |=> $stable(tx_snap[i]));
    // R5
    rx_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag[i] && rx_clr[i] && !rx_q) |=> !rx_flag[i]);
    // R6
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_q && !ts_all[i] && rx_clr[i]) |=> (rx_flag[i] && rx_snap[i] == $past(time_now)));
    // R7
    ta_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_all[i] && tx_q) |=> (tx_snap[i] == $past(time_now) && tx_flag[i] == $past(tx_flag[i])));
    // R11
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_flag[i] && !rx_q) |=> !rx_flag[i]);
    // R8
    status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'('h044 + 'h20 * i)) |->
        reg_rdata == {30'b0, rx_flag[i], tx_flag[i]});
  end
endmodule

bind ptp_snap_lock ptp_snap_lock_chk #(
  .NUM_CH(NUM_CH), .TIME_W(TIME_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .time_now(time_now),
  .role_master(role_master), .ts_all(ts_all),
  .rx_sync(rx_sync), .rx_dreq(rx_dreq), .tx_sync(tx_sync), .tx_dreq(tx_dreq),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .rx_flag(rx_flag), .tx_flag(tx_flag), .rx_clr(rx_clr), .tx_clr(tx_clr),
  .rx_snap(rx_snap), .tx_snap(tx_snap)
);

// File: tb/tb_ptp_snap_lock.sv
`timescale 1ns/1ps
module tb_ptp_snap_lock;
  localparam int NC = 8;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_now;
  logic [NC-1:0] role_master, ts_all, rx_sync, rx_dreq, tx_sync, tx_dreq;
  logic [8:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ptp_snap_lock dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .role_master(role_master), .ts_all(ts_all),
    .rx_sync(rx_sync), .rx_dreq(rx_dreq), .tx_sync(tx_sync), .tx_dreq(tx_dreq),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {ch[2:0], master, ta, strobes{rx_sync,rx_dreq,tx_sync,tx_dreq}, exp flags{rx,tx}, exp loads{rx,tx}}
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b0, 4'b0100, 2'b10, 2'b10},  // R1 master rx Delay_Req
    {3'd0, 1'b1, 1'b0, 4'b1000, 2'b00, 2'b00},  // R11 master rx Sync ignored
    {3'd1, 1'b0, 1'b0, 4'b1000, 2'b10, 2'b10},  // R1 slave rx Sync
    {3'd1, 1'b0, 1'b0, 4'b0100, 2'b00, 2'b00},  // R11 slave rx Delay_Req ignored
    {3'd2, 1'b1, 1'b0, 4'b0010, 2'b01, 2'b01},  // R2 master tx Sync
    {3'd2, 1'b0, 1'b0, 4'b0001, 2'b01, 2'b01},  // R2 slave tx Delay_Req
    {3'd3, 1'b0, 1'b0, 4'b0010, 2'b00, 2'b00},  // R11 slave tx Sync ignored
    {3'd7, 1'b1, 1'b0, 4'b1111, 2'b11, 2'b11},  // R3 both directions
    {3'd4, 1'b1, 1'b1, 4'b0110, 2'b00, 2'b11},  // R7 stamp-everything
    {3'd5, 1'b0, 1'b0, 4'b1001, 2'b11, 2'b11}   // R3 slave both
  };

  function automatic logic [8:0] a_of(input int ch, input int ofs);
    return 9'('h040 + 'h20 * ch + ofs);
  endfunction

  function automatic logic [63:0] t_of(input int v);
    return {32'hC0DE_0000 + 32'(v), 32'h0000_1000 + 32'(v)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(input logic [8:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 9'd4, hi);
    d = {hi, lo};
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int ch, input logic [3:0] stb, input logic [63:0] t);
    @(negedge clk);
    time_now = t;
    rx_sync[ch] = stb[3]; rx_dreq[ch] = stb[2];
    tx_sync[ch] = stb[1]; tx_dreq[ch] = stb[0];
    @(negedge clk);
    rx_sync = '0; rx_dreq = '0; tx_sync = '0; tx_dreq = '0;
  endtask

  initial begin
    #(150_000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] prx, ptx, s;
    rst_n = 1'b0; time_now = '0;
    role_master = '0; ts_all = '0;
    rx_sync = '0; rx_dreq = '0; tx_sync = '0; tx_dreq = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(a_of(0, 4), d); chk("R9 status ch0", d, 32'h0);
    rd(a_of(7, 4), d); chk("R9 status ch7", d, 32'h0);
    rd64(a_of(3, 8), s); chk("R9 rx snap ch3 lo", s[31:0], 32'h0);
    chk("R9 rx snap ch3 hi", s[63:32], 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int ch;
      ch = int'(VEC[v][12:10]);
      wr(a_of(ch, 4), 32'h3);
      role_master[ch] = VEC[v][9];
      ts_all[ch]      = VEC[v][8];
      rd64(a_of(ch, 8), prx);
      rd64(a_of(ch, 16), ptx);
      pulse(ch, VEC[v][7:4], t_of(v));
      rd(a_of(ch, 4), d);
      chk($sformatf("R3/R1/R2/R7/R11 flags vec%0d", v), d, {30'b0, VEC[v][3:2]});
      rd64(a_of(ch, 8), s);
      chk($sformatf("R3/R10 rx snap lo vec%0d", v), s[31:0], VEC[v][1] ? t_of(v)[31:0] : prx[31:0]);
      chk($sformatf("R3/R10 rx snap hi vec%0d", v), s[63:32], VEC[v][1] ? t_of(v)[63:32] : prx[63:32]);
      rd64(a_of(ch, 16), s);
      chk($sformatf("R3/R10 tx snap lo vec%0d", v), s[31:0], VEC[v][0] ? t_of(v)[31:0] : ptx[31:0]);
      chk($sformatf("R3/R10 tx snap hi vec%0d", v), s[63:32], VEC[v][0] ? t_of(v)[63:32] : ptx[63:32]);
      ts_all[ch] = 1'b0;
    end

    // R4 lock: ch6 slave, first Sync captures, second is held off
    role_master[6] = 1'b0;
    pulse(6, 4'b1000, 64'hAAAA_0001_BBBB_0001);
    pulse(6, 4'b1000, 64'hAAAA_0002_BBBB_0002);
    rd64(a_of(6, 8), s);
    chk("R4 locked rx snap lo", s[31:0], 32'hBBBB_0001);
    chk("R4 locked rx snap hi", s[63:32], 32'hAAAA_0001);

    // R5 zero bits and R8 reserved bits
    wr(a_of(6, 4), 32'hFFFF_FFFC);
    rd(a_of(6, 4), d);
    chk("R5 write zero keeps flag / R8 reserved zero", d, 32'h2);

    // R10 writes elsewhere do not clear
    wr(9'h000, 32'h3);
    wr(a_of(6, 8), 32'h3);
    rd(a_of(6, 4), d);
    chk("R10 stray writes ignored", d, 32'h2);
    rd(9'h000, d); chk("R10 unmapped low read", d, 32'h0);
    rd(9'h148, d); chk("R10 beyond last window", d, 32'h0);
    rd(a_of(6, 0), d); chk("R10 window word 0", d, 32'h0);

    // R12 clear ch5 leaves ch6 alone
    wr(a_of(5, 4), 32'h3);
    rd(a_of(5, 4), d); chk("R12 ch5 cleared", d, 32'h0);
    rd(a_of(6, 4), d); chk("R12 ch6 kept", d, 32'h2);

    // R6 set and clear in the same cycle on ch6 rx
    @(negedge clk);
    reg_addr = a_of(6, 4); reg_wdata = 32'h2; reg_wr = 1'b1;
    time_now = 64'hDDDD_0006_EEEE_0006; rx_sync[6] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; rx_sync = '0;
    rd(a_of(6, 4), d); chk("R6 flag survives clear", d, 32'h2);
    rd64(a_of(6, 8), s);
    chk("R6 snap takes new time lo", s[31:0], 32'hEEEE_0006);
    chk("R6 snap takes new time hi", s[63:32], 32'hDDDD_0006);
    pulse(6, 4'b1000, 64'h1111_2222_3333_4444);
    rd64(a_of(6, 8), s);
    chk("R6/R4 stays locked", s[31:0], 32'hEEEE_0006);

    // R5 clear then next event captures
    wr(a_of(6, 4), 32'h2);
    rd(a_of(6, 4), d); chk("R5 rx flag cleared", d, 32'h0);
    pulse(6, 4'b1000, 64'h5555_6666_7777_8888);
    rd64(a_of(6, 8), s);
    chk("R5 capture after clear", s[31:0], 32'h7777_8888);

    // R7 stamp-everything while locked leaves flag set
    rd(a_of(7, 4), d); chk("R7 ch7 flags before", d, 32'h3);
    ts_all[7] = 1'b1;
    pulse(7, 4'b0010, 64'h9999_0000_0000_9999);
    ts_all[7] = 1'b0;
    rd(a_of(7, 4), d); chk("R7 flags unchanged", d, 32'h3);
    rd64(a_of(7, 16), s); chk("R7 tx snap tracks", s[31:0], 32'h0000_9999);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule